// File: doc/BRIEF.md
# Rotating Program Counter Stack

This block keeps a small ring of full-width program counters and a pointer that names the one currently in use. The live program counter is always the entry under the pointer. A subroutine call or a restart does not copy a return address anywhere. It moves the pointer forward and writes the destination into the entry that is now selected. A return moves the pointer back, and the earlier entry, which was never touched, carries on from where it stopped.

Each cycle the sequencer that owns the block gives at most one intent. It may ask for a plain advance, with a skip count of zero to three bytes. It may give a jump, call or return command, each of which can be made conditional on one of four status flags. It may also ask for a restart into one of eight fixed vectors. When a conditional command is not taken, only the advance takes effect. This lets the caller step past the operand bytes of a jump or call that was not taken. The outputs are the active program counter and the pointer, and both are plain register outputs.

Top module: `pc_ring_stack`

## Requirements
- R1: An active-low asynchronous reset clears every entry and the pointer, so the active PC reads 0 and the pointer reads 0 in the cycle after reset.
- R2: When `step_en` is 1 and no command is taken, the active entry increases by `step_cnt` (0 to 3), modulo 2^14, so 0x3FFE plus 3 gives 0x0001.
- R3: A taken jump loads `tgt_addr` into the active entry and leaves the pointer unchanged.
- R4: A taken call first adds `step_cnt` to the current entry if `step_en` is 1. It then moves the pointer up by one and loads `tgt_addr` into the newly selected entry.
- R5: A taken return moves the pointer down by one. The active PC becomes the value stored in that entry, unchanged, and `step_en` is ignored.
- R6: A restart is never conditional. It acts like a call whose target has `rst_vec` in bits 5..3 and zeros in all other bits, so vector 7 gives 0x0038.
- R7: When `cond_en` is 1, a jump, call or return is taken only if flag bit `flags[cond_code[1:0]]` equals `cond_code[2]`. The flag bits are carry at bit 0, zero at bit 1, sign at bit 2 and parity at bit 3. A command that is not taken leaves only the R2 advance. When `cond_en` is 0, every command is taken.
- R8: The pointer wraps modulo 8 in both directions and has no overflow or underflow detection. A ninth nested call writes over the oldest entry.
- R9: When several strobes are high in the same cycle, only one acts. The priority is restart, then taken call, then taken jump, then taken return.
- R10: With no command taken and `step_en` at 0, the PC and the pointer hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance the active entry |
| step_cnt | input | 2 | Number of bytes to advance |
| tgt_addr | input | 14 | Jump or call destination |
| cond_en | input | 1 | Makes jump, call and return conditional |
| cond_code | input | 3 | Bit 2 is the required flag value; bits 1..0 select the flag |
| flags | input | 4 | Status flags: carry, zero, sign, parity (bit 0 to bit 3) |
| cmd_jump | input | 1 | Jump command |
| cmd_call | input | 1 | Call command |
| cmd_ret | input | 1 | Return command |
| cmd_restart | input | 1 | Restart command |
| rst_vec | input | 3 | Restart vector number |
| pc_out | output | 14 | Active program counter |
| sel_out | output | 3 | Pointer to the active entry |

## Verification
Several rules are checked by the assertions on every cycle. These are the pointer step on a push or a pop, the loaded target of a call, jump or restart, the zero state after reset, and holding when no command acts. Other behaviour shows only across a run of cycles. The bench scenarios cover it: a return brings back the exact caller value saved many cycles before, a ninth nested call overwrites the oldest entry, and returning from a fresh reset reads a cleared entry. A reference model driven by random commands compares both outputs on every cycle.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
   typedef enum logic [2:0] {
      PCS_HOLD,
      PCS_STEP,
      PCS_JUMP,
      PCS_PUSH,
      PCS_POP
   } pcs_op_e;
endpackage

// File: rtl/pcs_cond_eval.sv
module pcs_cond_eval #(
   parameter int FLAG_N = 4,
   localparam int SEL_W = $clog2(FLAG_N),
   localparam int CC_W  = SEL_W + 1
) (
   input  logic              cond_en,
   input  logic [CC_W-1:0]   cond_code,
   input  logic [FLAG_N-1:0] flags,
   output logic              take
);
   logic flag_bit;

   always_comb begin
      flag_bit = flags[cond_code[SEL_W-1:0]];
      take     = !cond_en || (flag_bit == cond_code[CC_W-1]);
   end
endmodule

// File: rtl/pcs_ptr.sv
module pcs_ptr #(
   parameter int PTR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up,
   input  logic             down,
   output logic [PTR_W-1:0] ptr,
   output logic [PTR_W-1:0] ptr_up
);
   // Wraps modulo 2**PTR_W by plain overflow of the register width.
   assign ptr_up = ptr + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (up) begin
         ptr <= ptr_up;
      end else if (down) begin
         ptr <= ptr - 1'b1;
      end
   end
endmodule

// File: rtl/pcs_file.sv
module pcs_file #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 14,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wa_en,
   input  logic [PTR_W-1:0]  wa_idx,
   input  logic [ADDR_W-1:0] wa_data,
   input  logic              wb_en,
   input  logic [PTR_W-1:0]  wb_idx,
   input  logic [ADDR_W-1:0] wb_data,
   input  logic [PTR_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_data
);
   logic [ADDR_W-1:0] ent [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      // Port B (new frame) wins; the two ports never name the same entry.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent[i] <= '0;
         end else if (wb_en && (wb_idx == PTR_W'(i))) begin
            ent[i] <= wb_data;
         end else if (wa_en && (wa_idx == PTR_W'(i))) begin
            ent[i] <= wa_data;
         end
      end
   end

   assign rd_data = ent[rd_idx];
endmodule

// File: rtl/pc_ring_stack.sv
module pc_ring_stack #(
   parameter int ADDR_W  = 14,
   parameter int DEPTH   = 8,
   parameter int STEP_W  = 2,
   parameter int FLAG_N  = 4,
   parameter int VEC_W   = 3,
   parameter int VEC_LSB = 3,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int CC_W   = $clog2(FLAG_N) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic [STEP_W-1:0] step_cnt,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic              cond_en,
   input  logic [CC_W-1:0]   cond_code,
   input  logic [FLAG_N-1:0] flags,
   input  logic              cmd_jump,
   input  logic              cmd_call,
   input  logic              cmd_ret,
   input  logic              cmd_restart,
   input  logic [VEC_W-1:0]  rst_vec,
   output logic [ADDR_W-1:0] pc_out,
   output logic [PTR_W-1:0]  sel_out
);
   import pcs_pkg::*;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pc_ring_stack: DEPTH must be a power of two, at least 2");
   end
   if (ADDR_W < VEC_LSB + VEC_W || STEP_W >= ADDR_W) begin : g_bad_width
      $error("pc_ring_stack: ADDR_W too narrow for vector field or step");
   end
   if (FLAG_N < 2 || (FLAG_N & (FLAG_N - 1)) != 0) begin : g_bad_flags
      $error("pc_ring_stack: FLAG_N must be a power of two");
   end

   logic              take;
   pcs_op_e           op;
   logic [PTR_W-1:0]  ptr, ptr_up;
   logic [ADDR_W-1:0] cur_pc, adv_pc, vec_pc, push_pc;
   logic              wa_en, wb_en;
   logic [ADDR_W-1:0] wa_data;

   pcs_cond_eval #(.FLAG_N(FLAG_N)) u_cond (
      .cond_en   (cond_en),
      .cond_code (cond_code),
      .flags     (flags),
      .take      (take)
   );

   always_comb begin
      if (cmd_restart)            op = PCS_PUSH;
      else if (cmd_call && take)  op = PCS_PUSH;
      else if (cmd_jump && take)  op = PCS_JUMP;
      else if (cmd_ret && take)   op = PCS_POP;
      else if (step_en)           op = PCS_STEP;
      else                        op = PCS_HOLD;
   end

   always_comb begin
      vec_pc = '0;
      vec_pc[VEC_LSB +: VEC_W] = rst_vec;
   end

   assign adv_pc  = cur_pc + ADDR_W'(step_cnt);
   assign push_pc = cmd_restart ? vec_pc : tgt_addr;
   assign wa_en   = (op == PCS_JUMP) || (op == PCS_STEP) || ((op == PCS_PUSH) && step_en);
   assign wa_data = (op == PCS_JUMP) ? tgt_addr : adv_pc;
   assign wb_en   = (op == PCS_PUSH);

   pcs_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .up     (op == PCS_PUSH),
      .down   (op == PCS_POP),
      .ptr    (ptr),
      .ptr_up (ptr_up)
   );

   pcs_file #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_file (
      .clk     (clk),
      .rst_n   (rst_n),
      .wa_en   (wa_en),
      .wa_idx  (ptr),
      .wa_data (wa_data),
      .wb_en   (wb_en),
      .wb_idx  (ptr_up),
      .wb_data (push_pc),
      .rd_idx  (ptr),
      .rd_data (cur_pc)
   );

   assign pc_out  = cur_pc;
   assign sel_out = ptr;
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
   parameter int ADDR_W  = 14,
   parameter int DEPTH   = 8,
   parameter int STEP_W  = 2,
   parameter int FLAG_N  = 4,
   parameter int VEC_W   = 3,
   parameter int VEC_LSB = 3,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int SEL_W  = $clog2(FLAG_N),
   localparam int CC_W   = SEL_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step_en,
   input logic [STEP_W-1:0] step_cnt,
   input logic [ADDR_W-1:0] tgt_addr,
   input logic              cond_en,
   input logic [CC_W-1:0]   cond_code,
   input logic [FLAG_N-1:0] flags,
   input logic              cmd_jump,
   input logic              cmd_call,
   input logic              cmd_ret,
   input logic              cmd_restart,
   input logic [VEC_W-1:0]  rst_vec,
   input logic [ADDR_W-1:0] pc_out,
   input logic [PTR_W-1:0]  sel_out
);
   logic ok, do_call, do_jump, do_ret;
   logic [ADDR_W-1:0] vec_exp;

   assign ok      = !cond_en || (flags[cond_code[SEL_W-1:0]] == cond_code[CC_W-1]);
   assign do_call = !cmd_restart && cmd_call && ok;
   assign do_jump = !cmd_restart && !(cmd_call && ok) && cmd_jump && ok;
   assign do_ret  = !cmd_restart && !(cmd_call && ok) && !(cmd_jump && ok) && cmd_ret && ok;

   always_comb begin
      vec_exp = '0;
      vec_exp[VEC_LSB +: VEC_W] = rst_vec;
   end

   a_r1_reset_zero: assert property (@(posedge clk)
      !rst_n |=> (pc_out == '0 && sel_out == '0));

   a_r4_push_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_restart || do_call) |=> sel_out == PTR_W'($past(sel_out) + 1'b1));

   a_r4_call_target: assert property (@(posedge clk) disable iff (!rst_n)
      do_call |=> pc_out == $past(tgt_addr));

   a_r6_vector: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_restart |=> pc_out == $past(vec_exp));

   a_r3_jump_load: assert property (@(posedge clk) disable iff (!rst_n)
      do_jump |=> (pc_out == $past(tgt_addr) && $stable(sel_out)));

   a_r5_pop_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      do_ret |=> sel_out == PTR_W'($past(sel_out) - 1'b1));

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_restart && !step_en && !((cmd_call || cmd_jump || cmd_ret) && ok))
      |=> ($stable(pc_out) && $stable(sel_out)));

   a_r7_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_en && !ok && !cmd_restart && !step_en) |=> ($stable(pc_out) && $stable(sel_out)));
endmodule

bind pc_ring_stack pcs_checker #(
   .ADDR_W(ADDR_W), .DEPTH(DEPTH), .STEP_W(STEP_W),
   .FLAG_N(FLAG_N), .VEC_W(VEC_W), .VEC_LSB(VEC_LSB)
) u_chk (
   .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_cnt(step_cnt),
   .tgt_addr(tgt_addr), .cond_en(cond_en), .cond_code(cond_code), .flags(flags),
   .cmd_jump(cmd_jump), .cmd_call(cmd_call), .cmd_ret(cmd_ret),
   .cmd_restart(cmd_restart), .rst_vec(rst_vec), .pc_out(pc_out), .sel_out(sel_out)
);

// File: tb/pc_ring_stack_tb.sv
`timescale 1ns/1ps
module pc_ring_stack_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_en = 1'b0;
   logic [1:0]  step_cnt = '0;
   logic [13:0] tgt_addr = '0;
   logic        cond_en = 1'b0;
   logic [2:0]  cond_code = '0;
   logic [3:0]  flags = '0;
   logic        cmd_jump = 1'b0, cmd_call = 1'b0, cmd_ret = 1'b0, cmd_restart = 1'b0;
   logic [2:0]  rst_vec = '0;
   logic [13:0] pc_out;
   logic [2:0]  sel_out;

   int n_chk = 0;
   int n_bad = 0;
   logic [13:0] m [8];
   logic [2:0]  mp;

   always #4 clk = ~clk;

   pc_ring_stack u_dut (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_cnt(step_cnt),
      .tgt_addr(tgt_addr), .cond_en(cond_en), .cond_code(cond_code), .flags(flags),
      .cmd_jump(cmd_jump), .cmd_call(cmd_call), .cmd_ret(cmd_ret),
      .cmd_restart(cmd_restart), .rst_vec(rst_vec), .pc_out(pc_out), .sel_out(sel_out)
   );

   function automatic logic cond_true(input logic ce, input logic [2:0] cc, input logic [3:0] fl);
      return !ce || (fl[cc[1:0]] == cc[2]);
   endfunction

   task automatic check(input string tag);
      n_chk++;
      if (pc_out !== m[mp] || sel_out !== mp) begin
         n_bad++;
         $display("FAIL %s: pc=%h sel=%0d expected pc=%h sel=%0d", tag, pc_out, sel_out, m[mp], mp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 8; i++) m[i] = '0;
      mp = '0;
   endtask

   // Drives one cycle at a falling edge, updates the model, checks at the next falling edge.
   task automatic cyc(input logic se, input logic [1:0] sc, input logic [13:0] t,
                      input logic ce, input logic [2:0] cc, input logic [3:0] fl,
                      input logic j, input logic c, input logic r, input logic rs,
                      input logic [2:0] v, input string tag);
      logic tk;
      step_en = se; step_cnt = sc; tgt_addr = t; cond_en = ce; cond_code = cc;
      flags = fl; cmd_jump = j; cmd_call = c; cmd_ret = r; cmd_restart = rs; rst_vec = v;
      tk = cond_true(ce, cc, fl);
      if (rs) begin
         if (se) m[mp] = m[mp] + 14'(sc);
         mp = mp + 3'd1; m[mp] = {8'd0, v, 3'd0};
      end else if (c && tk) begin
         if (se) m[mp] = m[mp] + 14'(sc);
         mp = mp + 3'd1; m[mp] = t;
      end else if (j && tk) begin
         m[mp] = t;
      end else if (r && tk) begin
         mp = mp - 3'd1;
      end else if (se) begin
         m[mp] = m[mp] + 14'(sc);
      end
      @(posedge clk);
      @(negedge clk);
      check(tag);
   endtask

   task automatic idle(input string tag);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      check("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset");

      // R1: a return straight out of reset exposes a cleared entry; R8 underflow wrap
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R1 R8 ret from empty");
      cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8 call back");

      // R2 advance and 14-bit wrap
      cyc(1, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 step1");
      cyc(1, 2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 step3");
      cyc(1, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 step0");
      cyc(0, 0, 14'h3FFE, 0, 0, 0, 1, 0, 0, 0, 0, "R3 jump");
      cyc(1, 2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 wrap");

      // R4 call with advance of caller, R5 return
      cyc(1, 2'd2, 14'h0100, 0, 0, 0, 0, 1, 0, 0, 0, "R4 call");
      cyc(1, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 in callee");
      cyc(1, 2'd3, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R5 return ignores step");

      // R6 restart vectors
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd7, "R6 vector7");
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R5 ret from vector");
      cyc(1, 2'd1, 0, 0, 0, 0, 0, 0, 0, 1, 3'd2, "R6 vector2 with advance");
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R5 ret");

      // R7 every condition code against two flag patterns
      for (int f = 0; f < 2; f++) begin
         for (int cc = 0; cc < 8; cc++) begin
            logic [3:0] fl;
            fl = (f == 0) ? 4'b0101 : 4'b1010;
            cyc(1, 2'd3, 14'(16'h0200 + cc), 1, 3'(cc), fl, 0, 1, 0, 0, 0, "R7 cond call");
            cyc(0, 0, 0, 1, 3'(cc), fl, 0, 0, 1, 0, 0, "R7 cond ret");
            cyc(0, 0, 14'(16'h0300 + cc), 1, 3'(cc), fl, 1, 0, 0, 0, 0, "R7 cond jump");
         end
      end

      // R8 nine nested calls, then nine returns
      for (int k = 0; k < 9; k++)
         cyc(1, 2'd2, 14'(16'h1000 + k * 16), 0, 0, 0, 0, 1, 0, 0, 0, "R8 nest call");
      for (int k = 0; k < 9; k++)
         cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R8 nest ret");

      // R9 priority
      cyc(1, 2'd1, 14'h0ABC, 0, 0, 0, 1, 1, 1, 1, 3'd5, "R9 restart wins");
      cyc(1, 2'd1, 14'h0ABD, 0, 0, 0, 1, 1, 1, 0, 0, "R9 call wins");
      cyc(1, 2'd1, 14'h0ABE, 0, 0, 0, 1, 0, 1, 0, 0, "R9 jump over ret");
      cyc(1, 2'd1, 14'h0ABF, 1, 3'b100, 4'b0000, 1, 1, 1, 0, 0, "R9 R7 none taken");

      // R10 hold
      idle("R10 idle");
      idle("R10 idle");
      cyc(0, 0, 14'h1234, 1, 3'b101, 4'b0000, 1, 1, 1, 0, 0, "R10 untaken no step");

      // mixed random traffic
      for (int k = 0; k < 3000; k++) begin
         int sel;
         logic j, c, r, rs;
         sel = int'($urandom_range(0, 9));
         j = (sel == 1) || (sel == 6);
         c = (sel == 2) || (sel == 7);
         r = (sel == 3) || (sel == 8);
         rs = (sel == 4);
         cyc(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 14'($urandom),
             1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)),
             j, c, r, rs, 3'($urandom_range(0, 7)), "R2 R3 R4 R5 R6 R7 random");
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule